// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives the six gate signals of a three-leg inverter. A shared timebase counts up and then back down, so every leg's pulse is centered on the middle of the period. Each leg compares the counter with its own duty value. That comparison gives a raw level, which is split into a high-side and a low-side signal with a programmable dead gap between them. Per-leg swap bits, per-pin enables and an optional chopping carrier then shape the final pins.

Software reaches the block through a plain register port: a write strobe, an address and data, and a combinational read. Period and duty writes go to shadow copies that take effect only at the start of the next period. A low level on the trip input blanks every pin in the same cycle. It also latches a sticky trip flag and clears the run bit. Software must clear the flag and set the run bit again before the pins come back.

Top module: `tpwm_gen`

## Requirements
- R1: After reset all six pins, the sync pulse, the phase bit and the trip flag are low. The control register (address 0) reads 0, which means all swap bits are clear, and the pin-enable register (address 3) reads 0.
- R2: While running, with the period register P at 1 or more, the sync pulse is high for exactly one cycle every 2*P cycles, in the cycle the counter restarts at zero counting up.
- R3: The phase output (also status bit 0 at address 5) is 0 during the P up-counting cycles and 1 during the P down-counting cycles of each period.
- R4: With zero dead time, leg i's high side is on for 2*D cycles per period and its low side for 2*P-2*D cycles, where D is its duty value (address 8+i). D of P or more gives a high side that is always on, and D of 0 gives one that is never on.
- R5: With dead time T (address 2, 10 bits, in clock cycles) and 0 < 2*D-T, the high side loses T cycles per period, the low side loses T cycles per period, and both sides are off for 2*T cycles per period. The two sides are never on together.
- R6: Control bit 3+i swaps leg i's high-side and low-side signals at its pins.
- R7: Pin-enable bit 2*i gates leg i's high pin and bit 2*i+1 gates its low pin. A cleared bit holds that pin low.
- R8: Control bit 1 ANDs the chopping carrier onto all high pins, and bit 2 ANDs it onto all low pins. The carrier toggles every N+1 cycles, where N is the byte at address 4.
- R9: A low trip input forces all six pins low in the same cycle. On the next clock edge it sets the trip flag (output and status bit 1) and clears the run bit (control bit 0). Status bit 2 reads the trip input level.
- R10: The trip flag stays set until a write of 1 to status bit 1. The pins stay low after the trip input is released, until the run bit is written to 1 again.
- R11: A duty or period write made in the middle of a period takes effect only at the next period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| trip_n | input | 1 | Active-low shutdown input |
| pwm_hi | output | 3 | High-side pins, one per leg |
| pwm_lo | output | 3 | Low-side pins, one per leg |
| sync_pulse | output | 1 | One-cycle pulse at each period start |
| half_phase | output | 1 | 1 while counting down |
| trip_irq | output | 1 | Sticky trip flag |

## Verification
The hardest case to reach is a duty write that lands in the middle of a period, where the old value must still shape the current pulse and the new one only the next pulse. The stimulus keeps a scoreboard of expected per-period on-times. After the first scored period completes, it writes a new duty value, so that the queued expectations change exactly one full period later. The trip sequence is also driven in stages: pull the input low, release it, wait a full period with the pins still blank, clear the flag, and then re-enable. This shows that each step alone is not enough to restart the outputs.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
  localparam int unsigned CW    = 16;
  localparam int unsigned DTW   = 10;
  localparam int unsigned NPAIR = 3;
  localparam int unsigned AW    = 4;

  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_PER   = 4'd1;
  localparam logic [AW-1:0] A_DT    = 4'd2;
  localparam logic [AW-1:0] A_OUTEN = 4'd3;
  localparam logic [AW-1:0] A_CHOP  = 4'd4;
  localparam logic [AW-1:0] A_STAT  = 4'd5;
  localparam int unsigned   A_DUTY0 = 8;

  // a zero period is treated as one
  function automatic logic [CW-1:0] per_eff(input logic [CW-1:0] p);
    return (p == '0) ? CW'(1) : p;
  endfunction

  // raw high-side level: on while the counter sits in the top D values
  function automatic logic pwm_level(input logic [CW-1:0] cnt,
                                     input logic [CW-1:0] per,
                                     input logic [CW-1:0] duty);
    if (duty >= per) return 1'b1;
    return cnt >= (per - duty);
  endfunction
endpackage

// File: rtl/tpwm_timebase.sv
module tpwm_timebase
  import tpwm_pkg::*;
#(
  parameter int unsigned W = CW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] per_in,
  output logic [W-1:0] cnt,
  output logic [W-1:0] per_s,
  output logic         down,
  output logic         sync,
  output logic         load
);
  assign load = !run || (down && cnt == '0);
  assign sync = run && !down && cnt == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      down  <= 1'b0;
      per_s <= W'(1);
    end else begin
      if (load) per_s <= per_eff(per_in);
      if (!run) begin
        cnt  <= '0;
        down <= 1'b0;
      end else if (!down) begin
        if (cnt >= per_s - W'(1)) down <= 1'b1;
        else                      cnt  <= cnt + W'(1);
      end else begin
        if (cnt == '0) down <= 1'b0;
        else           cnt  <= cnt - W'(1);
      end
    end
  end

  // R2
  sync_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> !sync);
  // R3
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && sync) |-> $past(down));
  // R11
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !sync) |-> $stable(per_s));
endmodule

// File: rtl/tpwm_chop.sv
module tpwm_chop (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [7:0] div,
  output logic       carrier
);
  logic [7:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      carrier <= 1'b1;
    end else if (!run) begin
      cnt     <= '0;
      carrier <= 1'b1;
    end else if (cnt >= div) begin
      cnt     <= '0;
      carrier <= !carrier;
    end else begin
      cnt <= cnt + 8'd1;
    end
  end
endmodule

// File: rtl/tpwm_pair.sv
module tpwm_pair
  import tpwm_pkg::*;
#(
  parameter int unsigned DW = DTW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          raw,
  input  logic [DW-1:0] dt,
  input  logic          xover,
  input  logic          carrier,
  input  logic          chop_hi,
  input  logic          chop_lo,
  input  logic          oe_hi,
  input  logic          oe_lo,
  input  logic          trip_n,
  output logic          out_hi,
  output logic          out_lo
);
  localparam logic [DW-1:0] SAT = '1;
  logic          raw_q;
  logic [DW-1:0] since;
  logic          hi_dt, lo_dt, side_a, side_b, gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      since <= '0;
    end else if (!run) begin
      raw_q <= 1'b0;
      since <= '0;
    end else begin
      raw_q <= raw;
      if (raw != raw_q)  since <= '0;
      else if (since != SAT) since <= since + DW'(1);
    end
  end

  assign hi_dt  = raw_q && (since >= dt);
  assign lo_dt  = !raw_q && (since >= dt);
  assign side_a = xover ? lo_dt : hi_dt;
  assign side_b = xover ? hi_dt : lo_dt;
  assign gate   = run && trip_n;
  assign out_hi = gate && oe_hi && side_a && (!chop_hi || carrier);
  assign out_lo = gate && oe_lo && side_b && (!chop_lo || carrier);

  // R5
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dt != '0 && $rose(hi_dt)) |-> $past(!lo_dt));
endmodule

// File: rtl/tpwm_gen.sv
module tpwm_gen
  import tpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [CW-1:0]    wdata,
  output logic [CW-1:0]    rdata,
  input  logic             trip_n,
  output logic [NPAIR-1:0] pwm_hi,
  output logic [NPAIR-1:0] pwm_lo,
  output logic             sync_pulse,
  output logic             half_phase,
  output logic             trip_irq
);
  localparam int unsigned XB = 3;

  logic               en_r, chop_hi_r, chop_lo_r, trip_flag;
  logic [NPAIR-1:0]   xover_r;
  logic [CW-1:0]      per_r;
  logic [DTW-1:0]     dt_r;
  logic [2*NPAIR-1:0] oe_r;
  logic [7:0]         chopdiv_r;
  logic [CW-1:0]      duty_r [NPAIR];
  logic [CW-1:0]      duty_s [NPAIR];
  logic [CW-1:0]      cnt, per_s;
  logic               down, load, carrier;
  logic               wr_ctrl, clr_trip;

  assign wr_ctrl  = wr_en && addr == A_CTRL;
  assign clr_trip = wr_en && addr == A_STAT && wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r <= 1'b0; chop_hi_r <= 1'b0; chop_lo_r <= 1'b0; xover_r <= '0;
      per_r <= CW'(1); dt_r <= '0; oe_r <= '0; chopdiv_r <= '0;
      trip_flag <= 1'b0;
      for (int i = 0; i < NPAIR; i++) duty_r[i] <= '0;
    end else begin
      if (!trip_n)      en_r <= 1'b0;
      else if (wr_ctrl) en_r <= wdata[0];
      if (wr_ctrl) begin
        chop_hi_r <= wdata[1];
        chop_lo_r <= wdata[2];
        xover_r   <= wdata[XB +: NPAIR];
      end
      if (wr_en && addr == A_PER)   per_r     <= wdata;
      if (wr_en && addr == A_DT)    dt_r      <= wdata[DTW-1:0];
      if (wr_en && addr == A_OUTEN) oe_r      <= wdata[2*NPAIR-1:0];
      if (wr_en && addr == A_CHOP)  chopdiv_r <= wdata[7:0];
      for (int i = 0; i < NPAIR; i++)
        if (wr_en && addr == AW'(A_DUTY0 + i)) duty_r[i] <= wdata;
      if (!trip_n)       trip_flag <= 1'b1;
      else if (clr_trip) trip_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAIR; i++) duty_s[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < NPAIR; i++) duty_s[i] <= duty_r[i];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  begin
        rdata[0] = en_r; rdata[1] = chop_hi_r; rdata[2] = chop_lo_r;
        rdata[XB +: NPAIR] = xover_r;
      end
      A_PER:   rdata = per_r;
      A_DT:    rdata[DTW-1:0] = dt_r;
      A_OUTEN: rdata[2*NPAIR-1:0] = oe_r;
      A_CHOP:  rdata[7:0] = chopdiv_r;
      A_STAT:  rdata[2:0] = {trip_n, trip_flag, down};
      default: for (int i = 0; i < NPAIR; i++)
                 if (addr == AW'(A_DUTY0 + i)) rdata = duty_r[i];
    endcase
  end

  tpwm_timebase #(.W(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(en_r), .per_in(per_r),
    .cnt(cnt), .per_s(per_s), .down(down), .sync(sync_pulse), .load(load)
  );

  tpwm_chop u_chop (
    .clk(clk), .rst_n(rst_n), .run(en_r), .div(chopdiv_r), .carrier(carrier)
  );

  for (genvar g = 0; g < NPAIR; g++) begin : g_leg
    logic raw;
    assign raw = pwm_level(cnt, per_s, duty_s[g]);
    tpwm_pair #(.DW(DTW)) u_pair (
      .clk(clk), .rst_n(rst_n), .run(en_r), .raw(raw), .dt(dt_r),
      .xover(xover_r[g]), .carrier(carrier),
      .chop_hi(chop_hi_r), .chop_lo(chop_lo_r),
      .oe_hi(oe_r[2*g]), .oe_lo(oe_r[2*g+1]), .trip_n(trip_n),
      .out_hi(pwm_hi[g]), .out_lo(pwm_lo[g])
    );
  end

  assign half_phase = down;
  assign trip_irq   = trip_flag;

  // R9
  trip_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_n |-> (pwm_hi == '0 && pwm_lo == '0));
  // R9
  trip_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_n |=> (trip_irq && !en_r));
  // R10
  trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_irq && !clr_trip) |=> trip_irq);
endmodule

// File: tb/tpwm_gen_bench.sv
`timescale 1ns/1ps
module tpwm_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        trip_n = 1'b1;
  logic [2:0]  pwm_hi, pwm_lo;
  logic        sync_pulse, half_phase, trip_irq;

  int nchk = 0, nfail = 0;
  int exp_q[$];
  int scb_done = 0;
  bit mon_en = 0, armed = 0;
  int acc = 0, e = 0;
  int m_hi[3], m_lo[3];
  int m_both_lo1, m_overlap, m_sync, m_phase, m_last_sync;
  localparam int PER = 10;

  always #2 clk = ~clk;

  tpwm_gen u_tpwm_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .trip_n(trip_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .sync_pulse(sync_pulse), .half_phase(half_phase), .trip_irq(trip_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    addr = 4'(a);
    #1 v = int'(rdata);
  endtask

  // counts over one period window: cycles after a sync up to and including the next sync
  task automatic measure();
    do @(negedge clk); while (!sync_pulse);
    for (int k = 0; k < 3; k++) begin m_hi[k] = 0; m_lo[k] = 0; end
    m_both_lo1 = 0; m_overlap = 0; m_sync = 0; m_phase = 0;
    for (int n = 0; n < 2*PER; n++) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        m_hi[k] += int'(pwm_hi[k]);
        m_lo[k] += int'(pwm_lo[k]);
        if (pwm_hi[k] && pwm_lo[k]) m_overlap++;
      end
      if (!pwm_hi[1] && !pwm_lo[1]) m_both_lo1++;
      m_sync  += int'(sync_pulse);
      m_phase += int'(half_phase);
      m_last_sync = int'(sync_pulse);
    end
  endtask

  // scoreboard monitor: on-time of leg 0 high pin per period
  always @(negedge clk) begin
    if (mon_en) begin
      if (sync_pulse) begin
        if (armed && exp_q.size() > 0) begin
          e = exp_q.pop_front();
          chk("R4 R11 scoreboard leg0 on-time", acc + int'(pwm_hi[0]), e);
          scb_done++;
        end
        armed = 1; acc = 0;
      end else acc += int'(pwm_hi[0]);
    end else begin
      armed = 0; acc = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 pins after reset", int'({pwm_hi, pwm_lo}), 0);
    chk("R1 sync/phase/trip after reset", int'({sync_pulse, half_phase, trip_irq}), 0);
    rd(0, v); chk("R1 ctrl reads zero", v, 0);
    rd(3, v); chk("R1 pin enables zero", v, 0);
    rd(5, v); chk("R1 status", v, 4);

    wr(1, PER); wr(8, 4); wr(9, 6); wr(10, 3); wr(2, 0); wr(3, 'h3F);
    // R11 scoreboard: duty 4 for two periods, then rewritten to 2
    exp_q.push_back(8); exp_q.push_back(8); exp_q.push_back(4); exp_q.push_back(4);
    mon_en = 1;
    wr(0, 1);
    wait (scb_done == 1);
    wr(8, 2);
    wait (scb_done == 4);
    mon_en = 0;
    chk("R11 scoreboard drained", exp_q.size(), 0);

    // R2 R3 R4
    measure();
    chk("R2 one sync per window", m_sync, 1);
    chk("R2 sync ends window of 2P", m_last_sync, 1);
    chk("R3 down half length", m_phase, PER);
    chk("R4 leg1 high", m_hi[1], 12);
    chk("R4 leg1 low", m_lo[1], 8);

    // R5
    wr(2, 3);
    measure(); measure();
    chk("R5 leg1 high dead", m_hi[1], 9);
    chk("R5 leg1 low dead", m_lo[1], 5);
    chk("R5 leg1 both off", m_both_lo1, 6);
    chk("R5 no overlap", m_overlap, 0);
    wr(2, 0);

    // R4 boundaries
    wr(9, 10);
    measure(); measure();
    chk("R4 full duty high", m_hi[1], 20);
    chk("R4 full duty low", m_lo[1], 0);
    wr(9, 0);
    measure(); measure();
    chk("R4 zero duty high", m_hi[1], 0);
    chk("R4 zero duty low", m_lo[1], 20);
    wr(9, 6);

    // R6 swap leg 2
    wr(0, 'h21);
    measure(); measure();
    chk("R6 leg2 high pin", m_hi[2], 14);
    chk("R6 leg2 low pin", m_lo[2], 6);

    // R7 mask leg0 high
    wr(0, 1); wr(3, 'h3E);
    measure(); measure();
    chk("R7 masked pin", m_hi[0], 0);
    chk("R7 partner pin", m_lo[0], 16);

    // R8 chop high pins every cycle
    wr(3, 'h3F); wr(4, 0); wr(0, 3);
    measure(); measure();
    chk("R8 leg0 chopped", m_hi[0], 2);
    chk("R8 leg1 chopped", m_hi[1], 6);
    chk("R8 leg1 low unchopped", m_lo[1], 8);
    wr(0, 1);

    // R9 trip
    measure();
    @(negedge clk); trip_n = 1'b0;
    #1 chk("R9 pins blank", int'({pwm_hi, pwm_lo}), 0);
    @(negedge clk);
    chk("R9 flag set", int'(trip_irq), 1);
    rd(5, v); chk("R9 status flag and pin", v & 6, 2);
    rd(0, v); chk("R9 run cleared", v & 1, 0);
    trip_n = 1'b1;
    // R10
    v = 0;
    for (int n = 0; n < 3*PER; n++) begin
      @(negedge clk);
      if (pwm_hi != 0 || pwm_lo != 0) v++;
    end
    chk("R10 pins stay low after release", v, 0);
    chk("R10 flag sticky", int'(trip_irq), 1);
    wr(5, 2);
    chk("R10 flag cleared", int'(trip_irq), 0);
    chk("R10 still blank before run", int'({pwm_hi, pwm_lo}), 0);
    wr(0, 1);
    measure(); measure();
    chk("R10 resume leg1", m_hi[1], 12);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule